// File: doc/BRIEF.md
# Five-Slot Register File with Constant Registers

This block is the general-purpose operand store of a wide-issue core that starts up to five operations per instruction. It holds 128 words of 32 bits. Each issue slot has two read ports and one write port. Reads are combinational. Writes commit at the rising clock edge.

Two register numbers are not storage:
- Register 0 always returns zero.
- Register 1 always returns one.

A write aimed at either of them is dropped and raises an error flag in the same cycle.

A read of a register that is being written in the current cycle returns the data being written. When several slots write one register in the same cycle, the highest-numbered slot decides the stored value, and a conflict flag reports the clash.

Top module: `mp_regfile`

## Requirements
- R1: Any register from 2 to 127 that is written with a 32-bit value returns that value on every read port after the clock edge, until it is written again.
- R2: A read port addressing register 0 returns 32'h0000_0000 at all times.
- R3: A read port addressing register 1 returns 32'h0000_0001 at all times.
- R4: In any cycle where an enabled slot addresses register 0 or 1, `const_wr_err` is 1 in that same cycle. It is 0 in every cycle with no such write. The write changes nothing that any port can observe.
- R5: All five slots can write five different registers in one cycle, and all five values are stored.
- R6: The ten read ports are independent. Read port p = 2*s + k (slot s, operand k) takes its address from bits [p*7 +: 7] of `rd_addr` and returns its data on bits [p*32 +: 32] of `rd_data`. Slot s writes using bit s of `wr_en`, bits [s*7 +: 7] of `wr_addr` and bits [s*32 +: 32] of `wr_data`.
- R7: A read port addressing a register from 2 to 127 that an enabled slot is writing in the current cycle returns that slot's write data without waiting for the edge. If several slots write that register, the port returns the data of the highest-numbered one.
- R8: When two or more enabled slots address the same register from 2 to 127 in one cycle, the highest-numbered of them sets the stored value and `wr_conflict` is 1 in that cycle. Otherwise `wr_conflict` is 0.
- R9: While `rst_n` is low at a clock edge, every register from 2 to 127 is cleared to zero.
- R10: A slot whose `wr_en` bit is 0 changes no register, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 70 | Ten 7-bit read addresses, port p at [p*7 +: 7] |
| rd_data | output | 320 | Ten 32-bit read results, port p at [p*32 +: 32] |
| wr_en | input | 5 | Per-slot write enable |
| wr_addr | input | 35 | Five 7-bit write addresses, slot s at [s*7 +: 7] |
| wr_data | input | 160 | Five 32-bit write values, slot s at [s*32 +: 32] |
| const_wr_err | output | 1 | A write to register 0 or 1 was attempted this cycle |
| wr_conflict | output | 1 | Two or more slots write one writable register this cycle |

## Verification
The bench checks the following corner cases. Each is listed with how a faulty design would fail it.
- **Constant registers.** Writes aimed at registers 0 and 1 must leave both reading as zero and one. A design that stores these writes would return the written data. A design that forgets the flag would keep `const_wr_err` low.
- **Write collisions.** Three slots and then two slots write one register. A priority inverted toward the lowest slot would store the wrong value and return the wrong bypass data.
- **Same-cycle reads.** A register being written is read through all ten ports in the same cycle. A design without bypass would return the old value until the edge.
- **Other cases.** The bench also checks disabled slots carrying live addresses, the top register 127, and the cleared state after reset.

// File: rtl/mp_regfile.sv
module mp_regfile #(
  parameter int SLOTS = 5,
  parameter int NREGS = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS),
  localparam int RPORTS = 2 * SLOTS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [RPORTS*AW-1:0]    rd_addr,
  output logic [RPORTS*WIDTH-1:0] rd_data,
  input  logic [SLOTS-1:0]        wr_en,
  input  logic [SLOTS*AW-1:0]     wr_addr,
  input  logic [SLOTS*WIDTH-1:0]  wr_data,
  output logic                    const_wr_err,
  output logic                    wr_conflict
);

  localparam int TOP = SLOTS - 1;

  logic [WIDTH-1:0] mem [NREGS];
  logic [AW-1:0]    wa  [SLOTS];
  logic [WIDTH-1:0] wd  [SLOTS];
  logic [SLOTS-1:0] live;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign wa[s]   = wr_addr[s*AW +: AW];
    assign wd[s]   = wr_data[s*WIDTH +: WIDTH];
    assign live[s] = wr_en[s] && (wa[s] > AW'(1));

    AST_CONST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[s] && wa[s] < AW'(2)) |-> const_wr_err); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) mem[r] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++)
        if (live[s]) mem[wa[s]] <= wd[s];
    end
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rd
    logic [AW-1:0]    ra;
    logic [WIDTH-1:0] rv;
    assign ra = rd_addr[p*AW +: AW];
    always_comb begin
      rv = mem[ra];
      for (int s = 0; s < SLOTS; s++)
        if (live[s] && wa[s] == ra) rv = wd[s];
      if (ra == AW'(0))      rv = '0;
      else if (ra == AW'(1)) rv = WIDTH'(1);
    end
    assign rd_data[p*WIDTH +: WIDTH] = rv;

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (ra == AW'(0)) |-> (rd_data[p*WIDTH +: WIDTH] == '0)); // R2
  end

  always_comb begin
    const_wr_err = 1'b0;
    for (int s = 0; s < SLOTS; s++)
      if (wr_en[s] && wa[s] < AW'(2)) const_wr_err = 1'b1;
  end

  always_comb begin
    wr_conflict = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      for (int j = i + 1; j < SLOTS; j++)
        if (live[i] && live[j] && wa[i] == wa[j]) wr_conflict = 1'b1;
  end

  AST_TOP_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[TOP] && wa[TOP] > AW'(1)) |=> (mem[$past(wa[TOP])] == $past(wd[TOP]))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> (mem[NREGS-1] == $past(mem[NREGS-1]))); // R10

  AST_BYPASS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[TOP] && wa[TOP] > AW'(1) && wa[TOP] == rd_addr[0 +: AW])
      |-> (rd_data[0 +: WIDTH] == wd[TOP])); // R7

  AST_CONFLICT_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> ($countones(wr_en) > 1)); // R8

endmodule

// File: tb/mp_regfile_bench.sv
module mp_regfile_bench;
  localparam int S = 5, N = 128, W = 32, AW = 7, RP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RP*AW-1:0] rd_addr = '0;
  logic [RP*W-1:0]  rd_data;
  logic [S-1:0]     wr_en = '0;
  logic [S*AW-1:0]  wr_addr = '0;
  logic [S*W-1:0]   wr_data = '0;
  logic             const_wr_err, wr_conflict;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] model [N];

  always #2 clk = ~clk;

  mp_regfile u_mp_regfile (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .const_wr_err(const_wr_err), .wr_conflict(wr_conflict));

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_rd(input int p, input int a);
    rd_addr[p*AW +: AW] = AW'(a);
  endtask

  task automatic set_wr(input int s, input bit en, input int a, input logic [W-1:0] d);
    wr_en[s] = en;
    wr_addr[s*AW +: AW] = AW'(a);
    wr_data[s*W +: W] = d;
  endtask

  function automatic logic [W-1:0] rd(input int p);
    return rd_data[p*W +: W];
  endfunction

  // Models the edge from the requirements, then lets it happen.
  task automatic tick();
    for (int s = 0; s < S; s++) begin
      int a = int'(wr_addr[s*AW +: AW]);
      if (wr_en[s] && a > 1) model[a] = wr_data[s*W +: W];
    end
    @(posedge clk); #1;
    wr_en = '0;
  endtask

  task automatic read_all_regs(input string tag);
    for (int base = 0; base < N; base += RP) begin
      for (int p = 0; p < RP; p++) set_rd(p, (base + p) % N);
      #1;
      for (int p = 0; p < RP; p++) begin
        int a = (base + p) % N;
        logic [W-1:0] e = (a == 0) ? 32'h0 : (a == 1) ? 32'h1 : model[a];
        check(rd(p) === e, tag, rd(p), e);
      end
    end
  endtask

  task automatic t_reset();
    for (int r = 0; r < N; r++) model[r] = '0;
    read_all_regs("R9 reset clear / R2 / R3");
    check(const_wr_err === 1'b0, "R4 idle err", {31'b0, const_wr_err}, 32'h0);
    check(wr_conflict === 1'b0, "R8 idle conflict", {31'b0, wr_conflict}, 32'h0);
  endtask

  task automatic t_five_slots();
    set_wr(0, 1, 2,   32'hA5A5_0002);
    set_wr(1, 1, 50,  32'h1234_5678);
    set_wr(2, 1, 100, 32'hDEAD_BEEF);
    set_wr(3, 1, 126, 32'hFFFF_FFFF);
    set_wr(4, 1, 127, 32'h8000_0001);
    #1;
    check(wr_conflict === 1'b0, "R8 distinct no conflict", {31'b0, wr_conflict}, 32'h0);
    check(const_wr_err === 1'b0, "R4 no const write", {31'b0, const_wr_err}, 32'h0);
    tick();
    read_all_regs("R1 R5 five-slot writes");
  endtask

  task automatic t_disabled();
    for (int s = 0; s < S; s++) set_wr(s, 0, 2 + s, 32'h0BAD_0000 + s);
    set_rd(0, 2);
    #1;
    check(rd(0) === model[2], "R10 disabled no bypass", rd(0), model[2]);
    @(posedge clk); #1;
    read_all_regs("R10 disabled slots");
  endtask

  task automatic t_const();
    set_wr(1, 1, 0, 32'hCAFE_0000);
    set_wr(3, 1, 1, 32'hCAFE_1111);
    set_rd(0, 0); set_rd(1, 1);
    #1;
    check(const_wr_err === 1'b1, "R4 flag raised", {31'b0, const_wr_err}, 32'h1);
    check(wr_conflict === 1'b0, "R8 const no conflict", {31'b0, wr_conflict}, 32'h0);
    check(rd(0) === 32'h0, "R2 reg0 during write", rd(0), 32'h0);
    check(rd(1) === 32'h1, "R3 reg1 during write", rd(1), 32'h1);
    tick();
    set_rd(0, 0); set_rd(1, 1);
    #1;
    check(const_wr_err === 1'b0, "R4 flag drops", {31'b0, const_wr_err}, 32'h0);
    check(rd(0) === 32'h0, "R2 reg0 after write", rd(0), 32'h0);
    check(rd(1) === 32'h1, "R3 reg1 after write", rd(1), 32'h1);
  endtask

  task automatic t_conflict();
    set_wr(0, 1, 7, 32'h0000_00A0);
    set_wr(2, 1, 7, 32'h0000_00A2);
    set_wr(4, 1, 7, 32'h0000_00A4);
    set_rd(3, 7);
    #1;
    check(wr_conflict === 1'b1, "R8 three-way conflict", {31'b0, wr_conflict}, 32'h1);
    check(rd(3) === 32'h0000_00A4, "R7 bypass top slot", rd(3), 32'h0000_00A4);
    tick();
    #1;
    check(rd(3) === 32'h0000_00A4, "R8 slot4 stored", rd(3), 32'h0000_00A4);
    set_wr(0, 1, 9, 32'h0000_0900);
    set_wr(1, 1, 9, 32'h0000_0901);
    set_rd(5, 9);
    #1;
    check(wr_conflict === 1'b1, "R8 two-way conflict", {31'b0, wr_conflict}, 32'h1);
    tick();
    #1;
    check(rd(5) === 32'h0000_0901, "R8 slot1 stored", rd(5), 32'h0000_0901);
    check(model[9] === 32'h0000_0901, "R8 model", model[9], 32'h0000_0901);
  endtask

  task automatic t_bypass_all_ports();
    set_wr(2, 1, 33, 32'h3333_CCCC);
    for (int p = 0; p < RP; p++) set_rd(p, 33);
    #1;
    for (int p = 0; p < RP; p++)
      check(rd(p) === 32'h3333_CCCC, "R7 R6 bypass every port", rd(p), 32'h3333_CCCC);
    tick();
    read_all_regs("R1 R6 after bypass");
  endtask

  task automatic t_reset_again();
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    for (int r = 0; r < N; r++) model[r] = '0;
    read_all_regs("R9 second reset");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_five_slots();
    t_disabled();
    t_const();
    t_conflict();
    t_bypass_all_ports();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule